// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block works out where an operand lives for a small 8/16-bit processor core. Given the current addressing mode and the operand bytes of the instruction, it produces a 24-bit effective address, split into an 8-bit bank and a 16-bit offset. It also produces the program counter a branch should load, the stack pointer after a stack access, a data word for immediate operands and push-relative results, the number of operand bytes the instruction carries, and a flag asking the sequencer for one extra cycle.

Five modes are handled: zero-bank direct-page, immediate, short relative branch, long relative branch or push, and stack. All 16-bit sums wrap within their bank and never carry into the bank byte. The logic is combinational. A parameter adds one register stage on all outputs, which gives a one-cycle latency.

Top module: `eff_addr_gen`

## Requirements
- R1: Direct mode (mode code 0) drives bank 0, drives an address equal to the direct-page register plus the zero-extended low operand byte modulo 2^16, and reports one operand byte.
- R2: The extra-cycle output is 1 exactly when the mode is direct and bits 7:0 of the direct-page register are not all zero. In every other case it is 0.
- R3: Immediate mode (mode code 1) reports 2 operand bytes and a data word of {high byte, low byte} when the wide flag is 1. When the wide flag is 0 it reports 1 byte and a data word of {8'h00, low byte}. Bank and address are 0.
- R4: Short relative mode (mode code 2) sign-extends the low operand byte and adds it to the next-instruction PC. The new PC is that sum when the condition input is 1 and the unchanged next-instruction PC when it is 0. The address equals the new PC, and one operand byte is reported.
- R5: Long relative mode (mode code 3) adds the signed 16-bit offset {high, low} to the next-instruction PC and places the sum on the address. When the push-relative input is 0, the new PC is the sum. When it is 1, the data word carries the sum and the new PC stays the next-instruction PC. Two operand bytes are reported.
- R6: In both relative modes the bank output equals the program-bank input, and the sums wrap modulo 2^16.
- R7: Stack mode (mode code 4) drives bank 0 and reports zero operand bytes. A push (pull input 0) addresses the stack pointer and returns the stack pointer minus 1. A pull addresses the stack pointer plus 1 and returns that same value. Both wrap modulo 2^16.
- R8: Mode codes 5 to 7 give zero bank, address, data, byte count and extra-cycle flag. They pass the next-instruction PC and the stack pointer through unchanged.
- R9: With REG_OUT=1 every output shows the result for the inputs sampled at the previous rising clock edge, and every output is 0 while rst_n is low. With REG_OUT=0 the outputs follow the inputs with no clock.
- R10: Outside stack mode the returned stack pointer equals the stack-pointer input. Outside relative modes the new PC equals the next-instruction PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| mode_i | input | 3 | Addressing mode code |
| op_lo_i | input | 8 | First operand byte |
| op_hi_i | input | 8 | Second operand byte |
| dp_i | input | 16 | Direct-page register |
| pc_next_i | input | 16 | PC already pointing at the next opcode |
| sp_i | input | 16 | Stack pointer |
| pbank_i | input | 8 | Program bank |
| wide_i | input | 1 | 16-bit immediate operand |
| cond_i | input | 1 | Short-branch condition met |
| push_rel_i | input | 1 | Long-relative result goes to the stack, not the PC |
| pull_i | input | 1 | Stack access is a pull (0 means push) |
| ea_bank_o | output | 8 | Effective bank |
| ea_addr_o | output | 16 | Effective 16-bit address |
| pc_new_o | output | 16 | Program counter to load |
| sp_new_o | output | 16 | Stack pointer after the access |
| data_o | output | 16 | Immediate operand or push-relative value |
| nbytes_o | output | 2 | Operand bytes of the instruction |
| extra_cyc_o | output | 1 | Request for one extra cycle |

## Verification
The bench builds two copies side by side. The instance `dut` uses REG_OUT=1, and a second instance uses REG_OUT=0, so the same stimulus checks both the one-cycle registered timing with its reset values and the purely combinational path. Directed vectors cover the corners: aligned and misaligned direct pages, offset wrap past 16'hFFFF, the extreme short and long displacements, stack wrap in both directions, and the unused mode codes. Random vectors across all eight codes then mix the flag inputs.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int OFS_W  = 16;
    localparam int BANK_W = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        AM_DIRECT = 3'd0,
        AM_IMM    = 3'd1,
        AM_REL8   = 3'd2,
        AM_REL16  = 3'd3,
        AM_STACK  = 3'd4
    } am_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  addr;
        logic [OFS_W-1:0]  pc_new;
        logic [OFS_W-1:0]  sp_new;
        logic [OFS_W-1:0]  data;
        logic [1:0]        nbytes;
        logic              extra;
    } ea_out_t;
endpackage

// File: rtl/eag_direct.sv
module eag_direct
    import eag_pkg::*;
(
    input  logic [OFS_W-1:0]  dp_i,
    input  logic [BYTE_W-1:0] ofs_i,
    output logic [OFS_W-1:0]  addr_o,
    output logic              misalign_o
);
    localparam int PAD_W = OFS_W - BYTE_W;

    always_comb begin
        addr_o     = dp_i + {{PAD_W{1'b0}}, ofs_i};
        misalign_o = |dp_i[BYTE_W-1:0];
    end
endmodule

// File: rtl/eag_rel.sv
module eag_rel
    import eag_pkg::*;
(
    input  logic [OFS_W-1:0]  pc_next_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    output logic [OFS_W-1:0]  short_tgt_o,
    output logic [OFS_W-1:0]  long_tgt_o
);
    localparam int EXT_W = OFS_W - BYTE_W;

    logic [OFS_W-1:0] short_ofs;

    always_comb begin
        short_ofs   = {{EXT_W{lo_i[BYTE_W-1]}}, lo_i};
        short_tgt_o = pc_next_i + short_ofs;
        long_tgt_o  = pc_next_i + {hi_i, lo_i};
    end
endmodule

// File: rtl/eag_stack.sv
module eag_stack
    import eag_pkg::*;
(
    input  logic [OFS_W-1:0] sp_i,
    input  logic             pull_i,
    output logic [OFS_W-1:0] addr_o,
    output logic [OFS_W-1:0] sp_new_o
);
    logic [OFS_W-1:0] sp_up;
    logic [OFS_W-1:0] sp_dn;

    always_comb begin
        sp_up = sp_i + OFS_W'(1);
        sp_dn = sp_i - OFS_W'(1);
        if (pull_i) begin
            addr_o   = sp_up;
            sp_new_o = sp_up;
        end else begin
            addr_o   = sp_i;
            sp_new_o = sp_dn;
        end
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [BYTE_W-1:0] op_lo_i,
    input  logic [BYTE_W-1:0] op_hi_i,
    input  logic [OFS_W-1:0]  dp_i,
    input  logic [OFS_W-1:0]  pc_next_i,
    input  logic [OFS_W-1:0]  sp_i,
    input  logic [BANK_W-1:0] pbank_i,
    input  logic              wide_i,
    input  logic              cond_i,
    input  logic              push_rel_i,
    input  logic              pull_i,
    output logic [BANK_W-1:0] ea_bank_o,
    output logic [OFS_W-1:0]  ea_addr_o,
    output logic [OFS_W-1:0]  pc_new_o,
    output logic [OFS_W-1:0]  sp_new_o,
    output logic [OFS_W-1:0]  data_o,
    output logic [1:0]        nbytes_o,
    output logic              extra_cyc_o
);
    logic [OFS_W-1:0] dir_addr;
    logic             dir_mis;
    logic [OFS_W-1:0] rel_short;
    logic [OFS_W-1:0] rel_long;
    logic [OFS_W-1:0] stk_addr;
    logic [OFS_W-1:0] stk_new;
    ea_out_t          out_d;
    ea_out_t          out_s;

    eag_direct u_direct (
        .dp_i       (dp_i),
        .ofs_i      (op_lo_i),
        .addr_o     (dir_addr),
        .misalign_o (dir_mis)
    );

    eag_rel u_rel (
        .pc_next_i   (pc_next_i),
        .lo_i        (op_lo_i),
        .hi_i        (op_hi_i),
        .short_tgt_o (rel_short),
        .long_tgt_o  (rel_long)
    );

    eag_stack u_stack (
        .sp_i     (sp_i),
        .pull_i   (pull_i),
        .addr_o   (stk_addr),
        .sp_new_o (stk_new)
    );

    always_comb begin
        out_d        = '0;
        out_d.pc_new = pc_next_i;
        out_d.sp_new = sp_i;
        case (am_e'(mode_i))
            AM_DIRECT: begin
                out_d.addr   = dir_addr;
                out_d.extra  = dir_mis;
                out_d.nbytes = 2'd1;
            end
            AM_IMM: begin
                out_d.nbytes = wide_i ? 2'd2 : 2'd1;
                out_d.data   = wide_i ? {op_hi_i, op_lo_i}
                                      : {{(OFS_W-BYTE_W){1'b0}}, op_lo_i};
            end
            AM_REL8: begin
                out_d.bank   = pbank_i;
                out_d.pc_new = cond_i ? rel_short : pc_next_i;
                out_d.addr   = out_d.pc_new;
                out_d.nbytes = 2'd1;
            end
            AM_REL16: begin
                out_d.bank   = pbank_i;
                out_d.addr   = rel_long;
                out_d.nbytes = 2'd2;
                if (push_rel_i) begin
                    out_d.data = rel_long;
                end else begin
                    out_d.pc_new = rel_long;
                end
            end
            AM_STACK: begin
                out_d.addr   = stk_addr;
                out_d.sp_new = stk_new;
            end
            default: ;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            ea_out_t out_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end
            assign out_s = out_q;
        end else begin : g_comb
            assign out_s = out_d;
        end
    endgenerate

    assign ea_bank_o   = out_s.bank;
    assign ea_addr_o   = out_s.addr;
    assign pc_new_o    = out_s.pc_new;
    assign sp_new_o    = out_s.sp_new;
    assign data_o      = out_s.data;
    assign nbytes_o    = out_s.nbytes;
    assign extra_cyc_o = out_s.extra;
endmodule

// File: rtl/eag_chk.sv
module eag_chk
    import eag_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic [BYTE_W-1:0] op_lo_i,
    input logic [BYTE_W-1:0] op_hi_i,
    input logic [OFS_W-1:0]  dp_i,
    input logic [OFS_W-1:0]  pc_next_i,
    input logic [OFS_W-1:0]  sp_i,
    input logic [BANK_W-1:0] pbank_i,
    input logic              wide_i,
    input logic              cond_i,
    input logic              push_rel_i,
    input logic              pull_i,
    input logic [BANK_W-1:0] ea_bank_o,
    input logic [OFS_W-1:0]  ea_addr_o,
    input logic [OFS_W-1:0]  pc_new_o,
    input logic [OFS_W-1:0]  sp_new_o,
    input logic [OFS_W-1:0]  data_o,
    input logic [1:0]        nbytes_o,
    input logic              extra_cyc_o
);
    logic [2:0]        m_s;
    logic [BYTE_W-1:0] lo_s;
    logic [OFS_W-1:0]  dp_s;
    logic [OFS_W-1:0]  sp_s;
    logic [BANK_W-1:0] pb_s;
    logic              pull_s;
    logic              vld;

    generate
        if (REG_OUT) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    m_s <= '0; lo_s <= '0; dp_s <= '0; sp_s <= '0;
                    pb_s <= '0; pull_s <= 1'b0; vld <= 1'b0;
                end else begin
                    m_s <= mode_i; lo_s <= op_lo_i; dp_s <= dp_i; sp_s <= sp_i;
                    pb_s <= pbank_i; pull_s <= pull_i; vld <= 1'b1;
                end
            end
        end else begin : g_direct
            assign m_s = mode_i;   assign lo_s = op_lo_i;
            assign dp_s = dp_i;    assign sp_s = sp_i;
            assign pb_s = pbank_i; assign pull_s = pull_i;
            assign vld = 1'b1;
        end
    endgenerate

    logic [OFS_W-1:0] dir_exp;
    assign dir_exp = dp_s + {8'h00, lo_s};

    a_r1_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && m_s == 3'd0) |-> (ea_bank_o == '0 && ea_addr_o == dir_exp));

    a_r2_extra_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (extra_cyc_o == (m_s == 3'd0 && dp_s[7:0] != 8'h00)));

    a_r6_rel_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && (m_s == 3'd2 || m_s == 3'd3)) |-> (ea_bank_o == pb_s));

    a_r7_stack_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && m_s == 3'd4) |-> (ea_bank_o == '0 && nbytes_o == 2'd0));

    a_r7_stack_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && m_s == 3'd4) |->
            (pull_s ? (sp_new_o == sp_s + 16'd1 && ea_addr_o == sp_new_o)
                    : (sp_new_o == sp_s - 16'd1 && ea_addr_o == sp_s)));

    a_r10_sp_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && m_s != 3'd4) |-> (sp_new_o == sp_s));

    a_r8_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && m_s > 3'd4) |-> (ea_addr_o == '0 && data_o == '0 && nbytes_o == 2'd0));
endmodule

bind eff_addr_gen eag_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_eff_addr_gen.sv
module tb_eff_addr_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [2:0]  mode;
    logic [7:0]  lo, hi, pb;
    logic [15:0] dp, pcn, sp;
    logic        wide, cond, pushr, pull;

    logic [7:0]  r_bank, c_bank;
    logic [15:0] r_addr, c_addr, r_pc, c_pc, r_sp, c_sp, r_data, c_data;
    logic [1:0]  r_nb, c_nb;
    logic        r_ex, c_ex;

    int checks = 0;
    int errors = 0;

    eff_addr_gen #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .op_lo_i(lo), .op_hi_i(hi),
        .dp_i(dp), .pc_next_i(pcn), .sp_i(sp), .pbank_i(pb), .wide_i(wide),
        .cond_i(cond), .push_rel_i(pushr), .pull_i(pull),
        .ea_bank_o(r_bank), .ea_addr_o(r_addr), .pc_new_o(r_pc), .sp_new_o(r_sp),
        .data_o(r_data), .nbytes_o(r_nb), .extra_cyc_o(r_ex));

    eff_addr_gen #(.REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .op_lo_i(lo), .op_hi_i(hi),
        .dp_i(dp), .pc_next_i(pcn), .sp_i(sp), .pbank_i(pb), .wide_i(wide),
        .cond_i(cond), .push_rel_i(pushr), .pull_i(pull),
        .ea_bank_o(c_bank), .ea_addr_o(c_addr), .pc_new_o(c_pc), .sp_new_o(c_sp),
        .data_o(c_data), .nbytes_o(c_nb), .extra_cyc_o(c_ex));

    // expected values, computed with integers
    int e_bank, e_addr, e_pc, e_sp, e_data, e_nb, e_ex;
    string e_req;

    task automatic model();
        int off;
        e_bank = 0; e_addr = 0; e_data = 0; e_nb = 0; e_ex = 0;
        e_pc = int'(pcn); e_sp = int'(sp);
        case (mode)
            3'd0: begin
                e_req = "R1/R2"; e_addr = (int'(dp) + int'(lo)) % 65536;
                e_ex = (int'(dp) % 256 != 0) ? 1 : 0; e_nb = 1;
            end
            3'd1: begin
                e_req = "R3"; e_nb = wide ? 2 : 1;
                e_data = wide ? int'(hi) * 256 + int'(lo) : int'(lo);
            end
            3'd2: begin
                e_req = "R4/R6";
                off = (lo >= 8'd128) ? int'(lo) - 256 : int'(lo);
                if (cond) e_pc = (int'(pcn) + off + 65536) % 65536;
                e_bank = int'(pb); e_addr = e_pc; e_nb = 1;
            end
            3'd3: begin
                e_req = "R5/R6";
                off = int'(hi) * 256 + int'(lo);
                if (off >= 32768) off = off - 65536;
                e_addr = (int'(pcn) + off + 65536) % 65536;
                e_bank = int'(pb); e_nb = 2;
                if (pushr) e_data = e_addr; else e_pc = e_addr;
            end
            3'd4: begin
                e_req = "R7/R10";
                if (pull) begin
                    e_addr = (int'(sp) + 1) % 65536; e_sp = e_addr;
                end else begin
                    e_addr = int'(sp); e_sp = (int'(sp) + 65535) % 65536;
                end
            end
            default: e_req = "R8/R10";
        endcase
    endtask

    task automatic cmp(string tag, logic [7:0] b, logic [15:0] a, logic [15:0] p,
                       logic [15:0] s, logic [15:0] d, logic [1:0] n, logic x);
        checks++;
        if (int'(b) != e_bank || int'(a) != e_addr || int'(p) != e_pc ||
            int'(s) != e_sp || int'(d) != e_data || int'(n) != e_nb || int'(x) != e_ex) begin
            errors++;
            $display("FAIL %s %s mode=%0d act bank=%h addr=%h pc=%h sp=%h data=%h nb=%0d ex=%0d exp bank=%h addr=%h pc=%h sp=%h data=%h nb=%0d ex=%0d",
                     tag, e_req, mode, b, a, p, s, d, n, x,
                     e_bank, e_addr, e_pc, e_sp, e_data, e_nb, e_ex);
        end
    endtask

    // drive at negedge, check comb copy, then registered copy after next posedge (R9)
    task automatic apply(logic [2:0] m, logic [7:0] l, logic [7:0] h, logic [15:0] d_,
                         logic [15:0] p_, logic [15:0] s_, logic [7:0] b_,
                         logic w, logic c, logic pr, logic pl);
        @(negedge clk);
        mode = m; lo = l; hi = h; dp = d_; pcn = p_; sp = s_; pb = b_;
        wide = w; cond = c; pushr = pr; pull = pl;
        #1;
        model();
        cmp("comb", c_bank, c_addr, c_pc, c_sp, c_data, c_nb, c_ex);
        @(posedge clk);
        #1;
        cmp("R9 reg", r_bank, r_addr, r_pc, r_sp, r_data, r_nb, r_ex);
    endtask

    initial begin
        #1600000;
        errors++; checks++;
        $display("FAIL watchdog R9 act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mode = 3'd1; lo = 8'hA5; hi = 8'h5A; dp = 16'h1234; pcn = 16'h4321;
        sp = 16'h01FF; pb = 8'h7E; wide = 1'b1; cond = 1'b1; pushr = 1'b0; pull = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state of the registered copy
        checks++;
        if ({r_bank, r_addr, r_pc, r_sp, r_data, r_nb, r_ex} != '0) begin
            errors++;
            $display("FAIL R9 reset act addr=%h pc=%h data=%h exp all zero", r_addr, r_pc, r_data);
        end
        @(negedge clk) rst_n = 1'b1;

        // R1/R2 direct: aligned, misaligned, wrap past FFFF
        apply(3'd0, 8'h34, 8'h00, 16'h1200, 16'h8000, 16'h0100, 8'h03, 0, 0, 0, 0);
        apply(3'd0, 8'h01, 8'h00, 16'h12FF, 16'h8000, 16'h0100, 8'h03, 0, 0, 0, 0);
        apply(3'd0, 8'h20, 8'h00, 16'hFFF0, 16'h8000, 16'h0100, 8'h03, 0, 0, 0, 0);
        // R3 immediate both widths
        apply(3'd1, 8'h11, 8'h22, 16'h00FF, 16'h8000, 16'h0100, 8'h03, 1, 0, 0, 0);
        apply(3'd1, 8'h11, 8'h22, 16'h00FF, 16'h8000, 16'h0100, 8'h03, 0, 0, 0, 0);
        // R4/R6 short branch: -128 with wrap, +127, not taken
        apply(3'd2, 8'h80, 8'h00, 16'h0000, 16'h0050, 16'h0100, 8'h12, 0, 1, 0, 0);
        apply(3'd2, 8'h7F, 8'h00, 16'h0000, 16'hFFC0, 16'h0100, 8'h12, 0, 1, 0, 0);
        apply(3'd2, 8'h7F, 8'h00, 16'h0000, 16'hFFC0, 16'h0100, 8'h12, 0, 0, 0, 0);
        // R5/R6 long: +32767 wrap, -32768, push-relative
        apply(3'd3, 8'hFF, 8'h7F, 16'h0000, 16'hFFFF, 16'h0100, 8'h34, 0, 0, 0, 0);
        apply(3'd3, 8'h00, 8'h80, 16'h0000, 16'h1000, 16'h0100, 8'h34, 0, 0, 0, 0);
        apply(3'd3, 8'h10, 8'h00, 16'h0000, 16'h2000, 16'h0100, 8'h34, 0, 0, 1, 0);
        // R7 stack wrap both ways
        apply(3'd4, 8'h00, 8'h00, 16'h0000, 16'h2000, 16'h0000, 8'h34, 0, 0, 0, 0);
        apply(3'd4, 8'h00, 8'h00, 16'h0000, 16'h2000, 16'hFFFF, 8'h34, 0, 0, 0, 1);
        // R8 unused codes
        apply(3'd5, 8'hFF, 8'hFF, 16'h1201, 16'h3333, 16'h4444, 8'h56, 1, 1, 1, 1);
        apply(3'd7, 8'hFF, 8'hFF, 16'h1201, 16'h3333, 16'h4444, 8'h56, 1, 1, 1, 1);

        for (int i = 0; i < 400; i++) begin
            apply(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 8'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule